// File: doc/BRIEF.md
# Shadowed Seconds Real-Time Clock

This block keeps wall-clock time as a binary seconds count plus a sub-second milliseconds count. It is advanced by a single-cycle enable, `slow_tick`, which marks each edge of a slow 32 kHz reference after it has been brought into the bus clock domain. A fixed number of ticks makes one millisecond. The milliseconds count wraps once per second and carries into the seconds count.

Software reads the time through a simple memory-mapped register port. The live counters are not read directly. After every group of eight slow ticks the block copies them into a bus-visible pair, and it holds a busy flag for a short window while it does so. Writes are accepted only while that flag is clear. A read of the milliseconds register also captures the visible seconds into a snapshot register, so a milliseconds read followed by a snapshot read yields a coherent pair.

Five event sources feed a sticky interrupt status register:
- two seconds-match alarms,
- one milliseconds-match alarm,
- a seconds countdown,
- a milliseconds countdown.

Each status bit is cleared by writing one to it. A mask register selects which sources drive the single active-high, level-sensitive interrupt line.

Top module: `shadow_rtc`

## Requirements
- R1: After reset every register reads zero (seconds, milliseconds, snapshot, alarms, countdowns, mask, status), the busy bit reads 0 and `irq` is low.
- R2: A write to the seconds register (offset 0x08) loads the seconds count and clears the milliseconds count and the sub-millisecond tick phase. Reads of 0x08 and 0x10 return the new values at once.
- R3: Reads of 0x08 (seconds) and 0x10 (milliseconds) return the visible copy. The copy is refreshed only on every COPY_EVERY-th slow tick counted from reset, and it then holds the counter values that result from that tick.
- R4: Bit 0 of the busy register (offset 0x04) reads 1 for BUSY_CYCLES bus clocks that start on the refresh tick, and reads 0 otherwise.
- R5: Any register write presented while busy is 1 has no effect.
- R6: A read of 0x10 captures the visible seconds into the snapshot register (offset 0x0C). The snapshot keeps that value, even if the seconds are rewritten, until the next read of 0x10.
- R7: The milliseconds count advances once every TICKS_PER_MS slow ticks. It steps from MS_PER_SEC-1 to 0, and that step increments the seconds count.
- R8: A seconds alarm register that holds zero never sets its status bit, including when the seconds count wraps to zero.
- R9: Status bit 0 (alarm register 0x14) and bit 1 (0x18) are set when the seconds count advances to the nonzero alarm value. Bit 2 (0x1C) is set when the milliseconds count advances to its nonzero alarm value.
- R10: Writing a 1 to a bit of the status register (offset 0x2C) clears that bit. Writing a 0 leaves it unchanged. Status bits otherwise only set.
- R11: `irq` is high exactly when some status bit is set and the same bit of the mask register (offset 0x28) is 1.
- R12: A write to 0x20 or 0x24 loads the seconds or milliseconds countdown. Each nonzero count decrements once per second or millisecond step. On reaching zero it sets status bit 3 (seconds) or bit 4 (milliseconds) and then stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable per slow reference edge |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read request |
| irq | output | 1 | Active-high level interrupt |

## Verification
The bound checker watches the following on every cycle:
- the busy window only begins on a slow tick;
- a mask write during busy leaves the mask untouched;
- the milliseconds count stays below its wrap value;
- status bits fall only after an accepted clear write;
- a zero alarm never raises bit 0;
- `irq` has a live masked source;
- an idle countdown stays at zero.

Some behaviours need whole scenarios, so only the bench can show them:
- the refresh timing of the visible copy;
- snapshot coherence across a seconds rewrite;
- the exact cycle an alarm or countdown lands;
- the wrap of the seconds count through zero.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

  // register byte offsets
  localparam logic [7:0] REG_BUSY   = 8'h04;
  localparam logic [7:0] REG_SECS   = 8'h08;
  localparam logic [7:0] REG_SNAP   = 8'h0C;
  localparam logic [7:0] REG_MSEC   = 8'h10;
  localparam logic [7:0] REG_ALM_S0 = 8'h14;
  localparam logic [7:0] REG_ALM_S1 = 8'h18;
  localparam logic [7:0] REG_ALM_MS = 8'h1C;
  localparam logic [7:0] REG_CDN_S  = 8'h20;
  localparam logic [7:0] REG_CDN_MS = 8'h24;
  localparam logic [7:0] REG_IMASK  = 8'h28;
  localparam logic [7:0] REG_ISTAT  = 8'h2C;

  // event bit positions in mask and status
  localparam int EV_SEC0  = 0;
  localparam int EV_SEC1  = 1;
  localparam int EV_MSEC  = 2;
  localparam int EV_CDN_S = 3;
  localparam int EV_CDN_M = 4;
  localparam int NUM_EV   = 5;

  typedef logic [NUM_EV-1:0] ev_vec_t;

  // an alarm hits when the counter lands on a nonzero target
  function automatic logic alarm_hit(input logic [31:0] value,
                                     input logic [31:0] target);
    return (target != 32'd0) && (value == target);
  endfunction

  // sticky status: clear-by-one first, new events win
  function automatic ev_vec_t status_next(input ev_vec_t cur,
                                          input ev_vec_t clr,
                                          input ev_vec_t set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int TICKS_PER_MS = 32,
  parameter int MS_PER_SEC   = 1000,
  parameter int COPY_EVERY   = 8,
  parameter int BUSY_CYCLES  = 4,
  localparam int MS_W  = $clog2(MS_PER_SEC + 1),
  localparam int PH_W  = $clog2(TICKS_PER_MS + 1),
  localparam int GRP_W = $clog2(COPY_EVERY + 1),
  localparam int BSY_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slow_tick,
  input  logic            sec_wr,
  input  logic [31:0]     sec_wdata,
  output logic [31:0]     sec_q,
  output logic [MS_W-1:0] ms_q,
  output logic [31:0]     sec_nxt,
  output logic [MS_W-1:0] ms_nxt,
  output logic            sec_step,
  output logic            ms_step,
  output logic [31:0]     vis_sec,
  output logic [MS_W-1:0] vis_ms,
  output logic            busy
);

  localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(TICKS_PER_MS - 1);
  localparam logic [MS_W-1:0]  LAST_MS  = MS_W'(MS_PER_SEC - 1);
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(COPY_EVERY - 1);

  logic [PH_W-1:0]  ph_q, ph_nxt;
  logic [GRP_W-1:0] grp_q;
  logic [BSY_W-1:0] bsy_q;
  logic             raw_ms_step, raw_sec_step, copy_now;

  always_comb begin
    raw_ms_step  = slow_tick && (ph_q == LAST_PH);
    raw_sec_step = raw_ms_step && (ms_q == LAST_MS);
    ph_nxt  = slow_tick ? ((ph_q == LAST_PH) ? '0 : ph_q + 1'b1) : ph_q;
    ms_nxt  = raw_ms_step ? ((ms_q == LAST_MS) ? '0 : ms_q + 1'b1) : ms_q;
    sec_nxt = raw_sec_step ? sec_q + 32'd1 : sec_q;
    copy_now = slow_tick && (grp_q == LAST_GRP);
    // a software load of the seconds overrides this cycle's advance
    ms_step  = raw_ms_step && !sec_wr;
    sec_step = raw_sec_step && !sec_wr;
    busy     = (bsy_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q   <= '0;
      ms_q    <= '0;
      ph_q    <= '0;
      vis_sec <= '0;
      vis_ms  <= '0;
    end else if (sec_wr) begin
      sec_q   <= sec_wdata;
      ms_q    <= '0;
      ph_q    <= '0;
      vis_sec <= sec_wdata;
      vis_ms  <= '0;
    end else begin
      sec_q <= sec_nxt;
      ms_q  <= ms_nxt;
      ph_q  <= ph_nxt;
      if (copy_now) begin
        vis_sec <= sec_nxt;
        vis_ms  <= ms_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
      bsy_q <= '0;
    end else begin
      if (slow_tick) grp_q <= (grp_q == LAST_GRP) ? '0 : grp_q + 1'b1;
      if (copy_now)            bsy_q <= BSY_W'(BUSY_CYCLES);
      else if (bsy_q != '0)    bsy_q <= bsy_q - 1'b1;
    end
  end

endmodule

// File: rtl/rtc_countdown.sv
module rtc_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             fire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign fire = step && !load && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (load)                  count <= load_val;
    else if (step && count != '0)   count <= count - ONE;
  end

endmodule

// File: rtl/shadow_rtc.sv
module shadow_rtc
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int TICKS_PER_MS = 32,
  parameter int MS_PER_SEC   = 1000,
  parameter int COPY_EVERY   = 8,
  parameter int BUSY_CYCLES  = 4,
  localparam int MS_W = $clog2(MS_PER_SEC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  logic [31:0]     sec_q, sec_nxt, vis_sec, snap_q;
  logic [MS_W-1:0] ms_q, ms_nxt, vis_ms;
  logic            sec_step, ms_step, busy;
  logic            wr_ok, rd_en;
  logic [31:0]     alm_s_q [2];
  logic [31:0]     alm_ms_q;
  ev_vec_t         mask_q, stat_q, ev_set, ev_clr;
  logic [31:0]     cd_count [2];
  logic            cd_load [2];
  logic            cd_fire [2];

  assign wr_ok = bus_sel && bus_we && !busy;
  assign rd_en = bus_sel && !bus_we;

  function automatic logic hit_reg(input logic [ADDR_W-1:0] a,
                                   input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  rtc_timebase #(
    .TICKS_PER_MS(TICKS_PER_MS), .MS_PER_SEC(MS_PER_SEC),
    .COPY_EVERY(COPY_EVERY), .BUSY_CYCLES(BUSY_CYCLES)
  ) tb_u (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .sec_wr(wr_ok && hit_reg(bus_addr, REG_SECS)), .sec_wdata(bus_wdata),
    .sec_q(sec_q), .ms_q(ms_q), .sec_nxt(sec_nxt), .ms_nxt(ms_nxt),
    .sec_step(sec_step), .ms_step(ms_step),
    .vis_sec(vis_sec), .vis_ms(vis_ms), .busy(busy)
  );

  // two seconds-match alarms share one structure
  for (genvar k = 0; k < 2; k++) begin : g_sec_alarm
    localparam logic [7:0] OFS = (k == 0) ? REG_ALM_S0 : REG_ALM_S1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alm_s_q[k] <= '0;
      else if (wr_ok && hit_reg(bus_addr, OFS)) alm_s_q[k] <= bus_wdata;
    end
    assign ev_set[EV_SEC0 + k] = sec_step && alarm_hit(sec_nxt, alm_s_q[k]);
  end

  // countdowns: index 0 counts seconds, index 1 counts milliseconds
  for (genvar k = 0; k < 2; k++) begin : g_cdn
    localparam logic [7:0] OFS = (k == 0) ? REG_CDN_S : REG_CDN_MS;
    assign cd_load[k] = wr_ok && hit_reg(bus_addr, OFS);
    rtc_countdown #(.CNT_W(32)) cd_u (
      .clk(clk), .rst_n(rst_n), .load(cd_load[k]), .load_val(bus_wdata),
      .step((k == 0) ? sec_step : ms_step),
      .count(cd_count[k]), .fire(cd_fire[k])
    );
    assign ev_set[EV_CDN_S + k] = cd_fire[k];
  end

  assign ev_set[EV_MSEC] = ms_step && alarm_hit(32'(ms_nxt), alm_ms_q);
  assign ev_clr = (wr_ok && hit_reg(bus_addr, REG_ISTAT)) ? bus_wdata[NUM_EV-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_ms_q <= '0;
      mask_q   <= '0;
      stat_q   <= '0;
      snap_q   <= '0;
    end else begin
      if (wr_ok && hit_reg(bus_addr, REG_ALM_MS)) alm_ms_q <= bus_wdata;
      if (wr_ok && hit_reg(bus_addr, REG_IMASK))  mask_q   <= bus_wdata[NUM_EV-1:0];
      stat_q <= status_next(stat_q, ev_clr, ev_set);
      if (rd_en && hit_reg(bus_addr, REG_MSEC))   snap_q   <= vis_sec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_en) begin
      if      (hit_reg(bus_addr, REG_BUSY))   bus_rdata <= {31'd0, busy};
      else if (hit_reg(bus_addr, REG_SECS))   bus_rdata <= vis_sec;
      else if (hit_reg(bus_addr, REG_SNAP))   bus_rdata <= snap_q;
      else if (hit_reg(bus_addr, REG_MSEC))   bus_rdata <= 32'(vis_ms);
      else if (hit_reg(bus_addr, REG_ALM_S0)) bus_rdata <= alm_s_q[0];
      else if (hit_reg(bus_addr, REG_ALM_S1)) bus_rdata <= alm_s_q[1];
      else if (hit_reg(bus_addr, REG_ALM_MS)) bus_rdata <= alm_ms_q;
      else if (hit_reg(bus_addr, REG_CDN_S))  bus_rdata <= cd_count[0];
      else if (hit_reg(bus_addr, REG_CDN_MS)) bus_rdata <= cd_count[1];
      else if (hit_reg(bus_addr, REG_IMASK))  bus_rdata <= 32'(mask_q);
      else if (hit_reg(bus_addr, REG_ISTAT))  bus_rdata <= 32'(stat_q);
      else                                    bus_rdata <= '0;
    end
  end

  assign irq = |(stat_q & mask_q);

endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int MS_PER_SEC = 1000,
  parameter int MS_W       = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slow_tick,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              busy,
  input logic [NUM_EV-1:0] mask_q,
  input logic [NUM_EV-1:0] stat_q,
  input logic [31:0]       alm0,
  input logic [MS_W-1:0]   ms_cur,
  input logic [31:0]       cd_s_count,
  input logic              cd_s_load,
  input logic              irq
);

  logic clr_wr;
  assign clr_wr = bus_sel && bus_we && !busy && (bus_addr == ADDR_W'(REG_ISTAT));

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(slow_tick));

  // R5
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_sel && bus_we && bus_addr == ADDR_W'(REG_IMASK)) |=> $stable(mask_q));

  // R7
  ms_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms_cur < MS_W'(MS_PER_SEC));

  // R8
  zero_alarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alm0 == 32'd0) |=> !$rose(stat_q[EV_SEC0]));

  // R10
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($countones(stat_q) > 0 && mask_q != '0));

  // R12
  countdown_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_s_count == 32'd0 && !cd_s_load) |=> (cd_s_count == 32'd0));

endmodule

bind shadow_rtc rtc_shadow_chk #(
  .ADDR_W(ADDR_W), .MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel),
  .bus_we(bus_we), .bus_addr(bus_addr), .busy(busy), .mask_q(mask_q),
  .stat_q(stat_q), .alm0(alm_s_q[0]), .ms_cur(ms_q),
  .cd_s_count(cd_count[0]), .cd_s_load(cd_load[0]), .irq(irq)
);

// File: tb/shadow_rtc_tb_top.sv
module shadow_rtc_tb_top;
  import rtc_shadow_pkg::*;

  localparam int TPM = 2;
  localparam int MPS = 5;
  localparam int GRP = 8;
  localparam int BSY = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #4 clk = ~clk;

  shadow_rtc #(.ADDR_W(8), .TICKS_PER_MS(TPM), .MS_PER_SEC(MPS),
               .COPY_EVERY(GRP), .BUSY_CYCLES(BSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  typedef struct { logic [31:0] exp; string tag; logic [7:0] addr; } item_t;
  item_t sb[$];

  // bench's own model of the clock
  int unsigned m_sec, m_ms, m_ph, m_grp, m_vsec, m_vms, m_snap;
  int unsigned m_al0, m_al1, m_alms, m_cds, m_cdm;
  logic [4:0]  m_mask, m_st;

  function automatic logic [31:0] model_val(input logic [7:0] a);
    case (a)
      8'h04: return 32'd0;
      8'h08: return m_vsec;
      8'h0C: return m_snap;
      8'h10: return m_vms;
      8'h14: return m_al0;
      8'h18: return m_al1;
      8'h1C: return m_alms;
      8'h20: return m_cds;
      8'h24: return m_cdm;
      8'h28: return {27'd0, m_mask};
      8'h2C: return {27'd0, m_st};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_tick();
    bit ms_adv, s_adv;
    ms_adv = 0; s_adv = 0;
    m_ph++;
    if (m_ph == TPM) begin m_ph = 0; ms_adv = 1; end
    if (ms_adv) begin
      if (m_ms == MPS - 1) begin m_ms = 0; m_sec++; s_adv = 1; end
      else m_ms++;
      if (m_alms != 0 && m_ms == m_alms) m_st[2] = 1'b1;
      if (m_cdm != 0) begin m_cdm--; if (m_cdm == 0) m_st[4] = 1'b1; end
    end
    if (s_adv) begin
      if (m_al0 != 0 && m_sec == m_al0) m_st[0] = 1'b1;
      if (m_al1 != 0 && m_sec == m_al1) m_st[1] = 1'b1;
      if (m_cds != 0) begin m_cds--; if (m_cds == 0) m_st[3] = 1'b1; end
    end
    m_grp++;
    if (m_grp == GRP) begin m_grp = 0; m_vsec = m_sec; m_vms = m_ms; end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
      model_tick();
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
    case (a)
      8'h08: begin m_sec = d; m_ms = 0; m_ph = 0; m_vsec = d; m_vms = 0; end
      8'h14: m_al0 = d;
      8'h18: m_al1 = d;
      8'h1C: m_alms = d;
      8'h20: m_cds = d;
      8'h24: m_cdm = d;
      8'h28: m_mask = d[4:0];
      8'h2C: m_st = m_st & ~d[4:0];
      default: ;
    endcase
  endtask

  task automatic rd_lit(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    it.exp = e; it.tag = tag; it.addr = a;
    sb.push_back(it);
    @(negedge clk); bus_sel = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    rd_lit(a, model_val(a), tag);
    if (a == 8'h10) m_snap = m_vsec;
  endtask

  task automatic chk_irq(input string tag);
    logic e;
    @(negedge clk);
    e = |(m_st & m_mask);
    vectors++;
    if (irq !== e) begin
      misses++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  // monitor: pops expected items when read data appears
  initial begin
    bit issued;
    item_t it;
    forever begin
      @(posedge clk); issued = bus_sel && !bus_we;
      @(negedge clk);
      if (issued && sb.size() > 0) begin
        it = sb.pop_front();
        vectors++;
        if (bus_rdata !== it.exp) begin
          misses++;
          $display("FAIL %s addr=%02h actual=%0h expected=%0h", it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    {m_sec, m_ms, m_ph, m_grp, m_vsec, m_vms, m_snap} = '0;
    {m_al0, m_al1, m_alms, m_cds, m_cdm} = '0;
    m_mask = '0; m_st = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_lit(8'h08, 0, "R1 seconds");
    rd_lit(8'h10, 0, "R1 msec");
    rd_lit(8'h04, 0, "R1 busy");
    rd_lit(8'h2C, 0, "R1 status");
    rd_lit(8'h28, 0, "R1 mask");
    rd_lit(8'h20, 0, "R1 countdown");
    chk_irq("R1");

    // R2: seconds load visible at once
    wr(8'h08, 32'd100);
    rd_lit(8'h08, 32'd100, "R2 seconds");
    rd_lit(8'h10, 32'd0, "R2 msec");

    // R3: copy only on group boundary; R7 ms advance
    tick(3);
    rd(8'h10, "R3 msec before copy");
    while (m_grp != 0) tick(1);
    rd(8'h10, "R3 msec after copy");
    rd(8'h08, "R3 seconds after copy");
    rd(8'h0C, "R6 snapshot after msec read");

    // R6: snapshot survives a seconds rewrite
    wr(8'h08, 32'd500);
    rd_lit(8'h0C, m_snap, "R6 snapshot held");
    rd(8'h10, "R6 msec read");
    rd_lit(8'h0C, 32'd500, "R6 snapshot refreshed");

    // R7: wrap of ms carries into seconds (10 ticks = 1 s)
    tick(2 * TPM * MPS);
    while (m_grp != 0) tick(1);
    rd(8'h08, "R7 seconds after wrap");
    rd(8'h10, "R7 msec after wrap");

    // R4, R5: busy window and write drop
    while (m_grp != GRP - 1) tick(1);
    @(negedge clk); slow_tick = 1'b1;
    @(negedge clk); slow_tick = 1'b0; model_tick();
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h1F;
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
    rd_lit(8'h04, 32'd1, "R4 busy during copy");
    rd(8'h28, "R5 mask write dropped");
    repeat (4) @(negedge clk);
    rd_lit(8'h04, 32'd0, "R4 busy released");

    // R9, R10, R11: seconds alarms
    wr(8'h08, 32'd200);
    wr(8'h14, 32'd201);
    wr(8'h18, 32'd202);
    tick(TPM * MPS);
    rd(8'h2C, "R9 alarm0 status");
    rd_lit(8'h2C, 32'h1, "R9 alarm0 literal");
    chk_irq("R11 masked off");
    wr(8'h28, 32'h1);
    chk_irq("R11 unmasked");
    wr(8'h2C, 32'h0);
    rd_lit(8'h2C, 32'h1, "R10 write zero keeps");
    wr(8'h2C, 32'h1);
    rd_lit(8'h2C, 32'h0, "R10 write one clears");
    chk_irq("R11 cleared");
    tick(TPM * MPS);
    rd_lit(8'h2C, 32'h2, "R9 alarm1 status");
    wr(8'h2C, 32'h1F);

    // R8: zero alarm silent through wrap to zero
    wr(8'h14, 32'd0);
    wr(8'h18, 32'd0);
    wr(8'h08, 32'hFFFF_FFFF);
    tick(TPM * MPS);
    rd_lit(8'h2C, 32'h0, "R8 zero alarm never fires");
    while (m_grp != 0) tick(1);
    rd(8'h08, "R8 seconds wrapped");

    // R9 ms alarm, R12 countdowns
    wr(8'h08, 32'd10);
    wr(8'h1C, 32'd3);
    wr(8'h20, 32'd2);
    wr(8'h24, 32'd3);
    wr(8'h28, 32'h1C);
    tick(TPM * 3);
    rd(8'h2C, "R9 msec alarm and R12 msec countdown");
    rd_lit(8'h24, 32'd0, "R12 msec countdown at zero");
    chk_irq("R11 ms sources");
    rd(8'h20, "R12 seconds countdown partial");
    tick(2 * TPM * MPS);
    rd(8'h2C, "R12 seconds countdown fired");
    rd_lit(8'h20, 32'd0, "R12 seconds countdown stopped");
    wr(8'h2C, 32'h1F);
    tick(TPM * MPS);
    rd(8'h2C, "R12 no refire after stop");
    chk_irq("R11 final");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule